// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Front End

This block is the software-visible register face of two IDE bus-master DMA channels. A 16-byte I/O window is split into two 8-byte slices, one per channel. Each slice carries a command byte, a status byte and a 32-bit descriptor-table pointer. The command byte's start bit is handed to the external DMA engine, and the pointer is exported for that engine to walk. The engine in turn reports interrupt and error events, which set sticky status bits that software clears by writing ones. The command and status bytes accept only byte-wide accesses.

A small configuration-space slice sits beside the I/O window. It holds a bus-master base register, an interrupt line/pin word, and one interrupt-pending byte per channel. Each pending flag follows that channel's interrupt request. The two flags are ORed, and the result is driven as a one-hot request on the output line whose number software has programmed. When the line number is zero, no line is driven.

Top module: `bmdma_regfront`

## Requirements
- R1: After reset: every command, status and pointer register reads 0. The line/pin dword reads 0x0000010E and the base register reads 0x0000CC01. Both pending flags and `irq_out` are 0.
- R2: Channel n owns I/O offsets 8n to 8n+7. Relative offset +0 is the command byte, +2 is the status byte, and +4 to +7 are the pointer bytes. Relative offsets +1 and +3 read 0xFF and ignore writes.
- R3: `io_size` encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. In the command/status half of a slice, a wider-than-byte read returns all ones for the access width (0x0000FFFF or 0xFFFFFFFF), and a wider write changes nothing.
- R4: A byte write W to status produces (W & 0x60) | (old & 0x01) | (old & ~W & 0x06). Bits 7, 4 and 3 always read 0.
- R5: A byte write to command stores all 8 bits. The same write copies bit 0 into status bit 0 and into `dma_start[n]`.
- R6: `evt_intr[n]` sets status bit 2 and `evt_err[n]` sets status bit 1. If a status write clears the same bit in the same cycle, the set wins.
- R7: The pointer accepts naturally aligned 1, 2 and 4 byte accesses, with data right-justified on the bus. Pointer bits 1:0 always read 0. A misaligned access reads all ones for its width and its write is ignored.
- R8: `io_rdata` and `cfg_rdata` carry the read result in the same cycle as the request, and read 0 when no read is requested. Register writes take effect at the next clock edge.
- R9: The pending flag of channel n is bit 7 of configuration byte 0x70+8n (dword index `cfg_addr[7:2]`). It equals `chan_irq[n]` as sampled at the previous edge, and configuration writes do not change it.
- R10: When either pending flag is set and the line number L is nonzero, `irq_out` equals 1<<L. Otherwise `irq_out` is 0.
- R11: In the line/pin dword at 0x3C, only bits 3:0 are writable (byte enable 0). The pin byte stays 0x01, and every other bit reads 0.
- R12: In the base register at 0x20, bits 15:4 are writable (byte enables 0 and 1). Bit 0 reads 1 and all other bits read 0. Unmapped configuration dwords read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O window access strobe |
| io_wr | input | 1 | I/O access is a write |
| io_addr | input | 4 | Byte offset in the 16-byte window |
| io_size | input | 2 | Access width code |
| io_wdata | input | 32 | Right-justified write data |
| io_rdata | output | 32 | Right-justified read data, same cycle |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_wr | input | 1 | Configuration access is a write |
| cfg_addr | input | 8 | Configuration byte address (dword index in 7:2) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, same cycle |
| chan_irq | input | 2 | Per-channel interrupt request level |
| evt_intr | input | 2 | Engine pulse: set status interrupt bit |
| evt_err | input | 2 | Engine pulse: set status error bit |
| dma_start | output | 2 | Command start bit per channel |
| dma_table_addr | output | 64 | Descriptor-table pointers, channel n at bits 32n+31:32n |
| irq_out | output | 16 | One-hot interrupt request lines |

## Verification
Read data is due in the cycle of the request. The bench therefore drives each stimulus just after a rising edge and samples both read buses at the following falling edge, before any register can move. Every register write, engine event and `chan_irq` change becomes visible one edge later, and `irq_out` follows the pending flags with no further delay. The behavioural model therefore updates its state one time unit after each rising edge, using the inputs that were held across that edge. All outputs are compared on every cycle: during directed sequences for each requirement, across a mid-run reset, and through a long stretch of pseudo-random mixed traffic.

// File: rtl/bmdma_pkg.sv
`timescale 1ns/1ps
package bmdma_pkg;

    localparam int unsigned SLICE_AW = 3;     // 8-byte slice per channel
    localparam int unsigned DW       = 32;

    localparam int unsigned ST_ACT = 0;
    localparam int unsigned ST_ERR = 1;
    localparam int unsigned ST_INT = 2;

    localparam logic [31:0] BASE_RST = 32'h0000_CC01;
    localparam logic [7:0]  PIN_VAL  = 8'h01;
    localparam logic [3:0]  LINE_RST = 4'hE;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } io_size_e;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  status;
        logic [29:0] tab;      // pointer bits 31:2
    } chan_regs_t;

    typedef struct packed {
        logic          wr_cmd;
        logic          wr_sts;
        logic [3:0]    tab_be;
        logic [DW-1:0] data;   // lane-aligned
    } chan_wr_t;

    function automatic logic [3:0] lane_mask(input io_size_e sz);
        case (sz)
            SZ_BYTE: return 4'h1;
            SZ_HALF: return 4'h3;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [DW-1:0] width_ones(input io_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic is_aligned(input io_size_e sz, input logic [1:0] lane);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~lane[0];
            default: return (lane == 2'd0);
        endcase
    endfunction

    // keep-active, write-through 6:5, write-one-to-clear 2:1
    function automatic logic [7:0] status_write(input logic [7:0] old, input logic [7:0] w);
        return (w & 8'h60) | (old & 8'h01) | (old & ~w & 8'h06);
    endfunction

endpackage

// File: rtl/bmdma_chan.sv
`timescale 1ns/1ps
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  chan_wr_t   wr,
    input  logic       evt_intr,
    input  logic       evt_err,
    output chan_regs_t regs
);

    chan_regs_t regs_q;
    chan_regs_t regs_d;
    logic [31:0] word;

    always_comb begin
        regs_d = regs_q;
        word   = {regs_q.tab, 2'b00};
        if (wr.wr_cmd) begin
            regs_d.cmd            = wr.data[7:0];
            regs_d.status[ST_ACT] = wr.data[0];
        end
        if (wr.wr_sts) begin
            regs_d.status = status_write(regs_q.status, wr.data[7:0]);
        end
        for (int b = 0; b < 4; b++) begin
            if (wr.tab_be[b]) begin
                word[b*8 +: 8] = wr.data[b*8 +: 8];
            end
        end
        regs_d.tab = word[31:2];
        // engine events override a same-cycle clear
        if (evt_intr) regs_d.status[ST_INT] = 1'b1;
        if (evt_err)  regs_d.status[ST_ERR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/bmdma_io_decode.sv
`timescale 1ns/1ps
module bmdma_io_decode
    import bmdma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = $clog2(NCH) + 3
) (
    input  logic                   io_req,
    input  logic                   io_wr,
    input  logic [ADDR_W-1:0]      io_addr,
    input  logic [1:0]             io_size,
    input  logic [DW-1:0]          io_wdata,
    input  chan_regs_t [NCH-1:0]   regs,
    output chan_wr_t   [NCH-1:0]   wr,
    output logic [DW-1:0]          io_rdata
);

    io_size_e                 sz;
    logic [ADDR_W-4:0]        ch;
    logic                     in_tab;
    logic [1:0]               lane;
    logic                     rd_req;
    logic                     wr_req;

    assign sz     = io_size_e'(io_size);
    assign ch     = io_addr[ADDR_W-1:SLICE_AW];
    assign in_tab = io_addr[2];
    assign lane   = io_addr[1:0];
    assign rd_req = io_req & ~io_wr;
    assign wr_req = io_req &  io_wr;

    always_comb begin
        wr       = '0;
        io_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(ch) == c) begin
                if (!in_tab) begin
                    // command/status half: byte accesses only (R3)
                    if (sz == SZ_BYTE) begin
                        wr[c].wr_cmd = wr_req && (lane == 2'd0);
                        wr[c].wr_sts = wr_req && (lane == 2'd2);
                        wr[c].data   = io_wdata;
                        if (rd_req) begin
                            case (lane)
                                2'd0:    io_rdata = {24'h0, regs[c].cmd};
                                2'd2:    io_rdata = {24'h0, regs[c].status};
                                default: io_rdata = 32'h0000_00FF;
                            endcase
                        end
                    end else if (rd_req) begin
                        io_rdata = width_ones(sz);
                    end
                end else begin
                    // pointer half: aligned lanes (R7)
                    if (is_aligned(sz, lane)) begin
                        wr[c].tab_be = wr_req ? 4'(lane_mask(sz) << lane) : 4'h0;
                        wr[c].data   = io_wdata << (8 * lane);
                        if (rd_req) begin
                            io_rdata = ({regs[c].tab, 2'b00} >> (8 * lane)) & width_ones(sz);
                        end
                    end else if (rd_req) begin
                        io_rdata = width_ones(sz);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bmdma_cfg.sv
`timescale 1ns/1ps
module bmdma_cfg
    import bmdma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [NCH-1:0]    chan_irq,
    output logic [DW-1:0]     cfg_rdata,
    output logic [LINE_W-1:0] line,
    output logic [NCH-1:0]    pend
);

    localparam logic [5:0] BASE_IDX    = 6'h08;   // byte 0x20
    localparam logic [5:0] LINE_IDX    = 6'h0F;   // byte 0x3C
    localparam int         PEND_IDX0   = 'h1C;    // byte 0x70
    localparam int         PEND_STRIDE = 2;       // 8 bytes apart

    logic [5:0]        idx;
    logic [11:0]       base_q;
    logic [LINE_W-1:0] line_q;
    logic [NCH-1:0]    pend_q;
    logic              unused_cfg;

    assign idx        = cfg_addr[7:2];
    assign unused_cfg = ^{cfg_addr[1:0], cfg_be[3:2], cfg_wdata[31:16], cfg_wdata[3:LINE_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= BASE_RST[15:4];
            line_q <= LINE_W'(LINE_RST);
            pend_q <= '0;
        end else begin
            pend_q <= chan_irq;
            if (cfg_req && cfg_wr) begin
                if (idx == BASE_IDX) begin
                    if (cfg_be[0]) base_q[3:0]  <= cfg_wdata[7:4];
                    if (cfg_be[1]) base_q[11:4] <= cfg_wdata[15:8];
                end
                if (idx == LINE_IDX && cfg_be[0]) begin
                    line_q <= cfg_wdata[LINE_W-1:0];
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_req && !cfg_wr) begin
            if (idx == BASE_IDX) begin
                cfg_rdata = {16'h0, base_q, 4'b0001};
            end else if (idx == LINE_IDX) begin
                cfg_rdata = {16'h0, PIN_VAL, {(8-LINE_W){1'b0}}, line_q};
            end
            for (int c = 0; c < NCH; c++) begin
                if (int'(idx) == PEND_IDX0 + PEND_STRIDE * c) begin
                    cfg_rdata = {24'h0, pend_q[c], 7'h0};
                end
            end
        end
    end

    assign line = line_q;
    assign pend = pend_q;

endmodule

// File: rtl/bmdma_irq_route.sv
`timescale 1ns/1ps
module bmdma_irq_route #(
    parameter int NCH    = 2,
    parameter int LINE_W = 4,
    parameter int NLINES = 1 << LINE_W
) (
    input  logic [NCH-1:0]    pend,
    input  logic [LINE_W-1:0] line,
    output logic [NLINES-1:0] irq_out
);

    logic level;
    assign level = |pend;

    always_comb begin
        irq_out = '0;
        if (level && (line != '0)) begin
            irq_out[line] = 1'b1;
        end
    end

endmodule

// File: rtl/bmdma_regfront.sv
`timescale 1ns/1ps
module bmdma_regfront
    import bmdma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int LINE_W = 4,
    parameter int ADDR_W = $clog2(NCH) + 3,
    parameter int NLINES = 1 << LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [NCH-1:0]    chan_irq,
    input  logic [NCH-1:0]    evt_intr,
    input  logic [NCH-1:0]    evt_err,
    output logic [NCH-1:0]    dma_start,
    output logic [NCH*32-1:0] dma_table_addr,
    output logic [NLINES-1:0] irq_out
);

    chan_regs_t [NCH-1:0] regs;
    chan_wr_t   [NCH-1:0] wr;
    logic [NCH*8-1:0]     chan_status;
    logic [LINE_W-1:0]    cfg_line;
    logic [NCH-1:0]       cfg_pend;

    bmdma_io_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
        .io_req   (io_req),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_size  (io_size),
        .io_wdata (io_wdata),
        .regs     (regs),
        .wr       (wr),
        .io_rdata (io_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bmdma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr[c]),
            .evt_intr (evt_intr[c]),
            .evt_err  (evt_err[c]),
            .regs     (regs[c])
        );
        assign dma_start[c]             = regs[c].cmd[0];
        assign dma_table_addr[c*32 +: 32] = {regs[c].tab, 2'b00};
        assign chan_status[c*8 +: 8]      = regs[c].status;
    end

    bmdma_cfg #(.NCH(NCH), .LINE_W(LINE_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_req   (cfg_req),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .chan_irq  (chan_irq),
        .cfg_rdata (cfg_rdata),
        .line      (cfg_line),
        .pend      (cfg_pend)
    );

    bmdma_irq_route #(.NCH(NCH), .LINE_W(LINE_W), .NLINES(NLINES)) u_route (
        .pend    (cfg_pend),
        .line    (cfg_line),
        .irq_out (irq_out)
    );

endmodule

// File: rtl/bmdma_regfront_chk.sv
`timescale 1ns/1ps
module bmdma_regfront_chk #(
    parameter int NCH    = 2,
    parameter int LINE_W = 4,
    parameter int ADDR_W = $clog2(NCH) + 3,
    parameter int NLINES = 1 << LINE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              io_req,
    input logic              io_wr,
    input logic [ADDR_W-1:0] io_addr,
    input logic [1:0]        io_size,
    input logic [NCH-1:0]    chan_irq,
    input logic [NCH-1:0]    dma_start,
    input logic [NCH*8-1:0]  chan_status,
    input logic [LINE_W-1:0] line,
    input logic [NCH-1:0]    pend,
    input logic [NLINES-1:0] irq_out
);

    assert_line_zero_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (line == '0) |-> (irq_out == '0));

    assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_out));

    assert_pend_follows_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pend == $past(chan_irq)));

    assert_wide_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (io_req && io_wr && io_size != 2'd0 && !io_addr[2]) |=> $stable(dma_start));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assert_start_needs_cmd_write_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(dma_start[c]) |->
                $past(io_req && io_wr && io_size == 2'd0 && io_addr == ADDR_W'(c * 8)));

        assert_active_tracks_start_R5: assert property (@(posedge clk) disable iff (rst)
            chan_status[c*8] == dma_start[c]);

        assert_reserved_status_zero_R4: assert property (@(posedge clk) disable iff (rst)
            (chan_status[c*8 +: 8] & 8'h98) == 8'h00);
    end

endmodule

bind bmdma_regfront bmdma_regfront_chk #(
    .NCH(NCH), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .NLINES(NLINES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .io_req      (io_req),
    .io_wr       (io_wr),
    .io_addr     (io_addr),
    .io_size     (io_size),
    .chan_irq    (chan_irq),
    .dma_start   (dma_start),
    .chan_status (chan_status),
    .line        (cfg_line),
    .pend        (cfg_pend),
    .irq_out     (irq_out)
);

// File: tb/bmdma_regfront_bench.sv
`timescale 1ns/1ps
module bmdma_regfront_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_req, io_wr;
    logic [3:0]  io_addr;
    logic [1:0]  io_size;
    logic [31:0] io_wdata, io_rdata;
    logic        cfg_req, cfg_wr;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic [1:0]  chan_irq, evt_intr, evt_err, dma_start;
    logic [63:0] dma_table_addr;
    logic [15:0] irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural model state
    logic [7:0]  m_cmd [2];
    logic [7:0]  m_st  [2];
    logic [31:0] m_tab [2];
    logic [1:0]  m_pend;
    logic [3:0]  m_line;
    logic [31:0] m_base;

    bmdma_regfront u_bmdma_regfront (
        .clk(clk), .rst(rst),
        .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr), .io_size(io_size),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .chan_irq(chan_irq), .evt_intr(evt_intr), .evt_err(evt_err),
        .dma_start(dma_start), .dma_table_addr(dma_table_addr), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ones(input int nb);
        return (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
    endfunction

    function automatic logic [31:0] exp_io_rdata();
        int ch, off, ln, nb;
        if (!(io_req && !io_wr)) return 32'h0;
        ch = int'(io_addr) / 8; off = int'(io_addr) % 8; ln = off % 4;
        nb = nbytes(io_size);
        if (off < 4) begin
            if (nb != 1) return ones(nb);
            if (ln == 0) return {24'h0, m_cmd[ch]};
            if (ln == 2) return {24'h0, m_st[ch]};
            return 32'h0000_00FF;
        end
        if (ln % nb != 0) return ones(nb);
        return (m_tab[ch] >> (8 * ln)) & ones(nb);
    endfunction

    function automatic logic [31:0] exp_cfg_rdata();
        if (!(cfg_req && !cfg_wr)) return 32'h0;
        case (cfg_addr & 8'hFC)
            8'h20:   return m_base;
            8'h3C:   return {16'h0, 8'h01, 4'h0, m_line};
            8'h70:   return {24'h0, m_pend[0], 7'h0};
            8'h78:   return {24'h0, m_pend[1], 7'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_irq();
        if ((m_pend != 2'b00) && (m_line != 4'h0)) return 16'h1 << m_line;
        return 16'h0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got 0x%0h exp 0x%0h", tag, what, got, exp);
        end
    endtask

    task automatic model_update();
        int ch, off, ln, nb;
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_cmd[c] = 8'h0; m_st[c] = 8'h0; m_tab[c] = 32'h0;
            end
            m_pend = 2'b00; m_line = 4'hE; m_base = 32'h0000_CC01;
            return;
        end
        if (io_req && io_wr) begin
            ch = int'(io_addr) / 8; off = int'(io_addr) % 8; ln = off % 4;
            nb = nbytes(io_size);
            if (off < 4) begin
                if (nb == 1 && ln == 0) begin
                    m_cmd[ch] = io_wdata[7:0];
                    m_st[ch]  = {m_st[ch][7:1], io_wdata[0]};
                end else if (nb == 1 && ln == 2) begin
                    m_st[ch] = (io_wdata[7:0] & 8'h60) | (m_st[ch] & 8'h01)
                             | (m_st[ch] & ~io_wdata[7:0] & 8'h06);
                end
            end else if (ln % nb == 0) begin
                for (int b = 0; b < nb; b++) m_tab[ch][(ln+b)*8 +: 8] = io_wdata[b*8 +: 8];
                m_tab[ch][1:0] = 2'b00;
            end
        end
        for (int c = 0; c < 2; c++) begin
            if (evt_intr[c]) m_st[c][2] = 1'b1;
            if (evt_err[c])  m_st[c][1] = 1'b1;
        end
        if (cfg_req && cfg_wr) begin
            if ((cfg_addr & 8'hFC) == 8'h20) begin
                if (cfg_be[0]) m_base[7:4]  = cfg_wdata[7:4];
                if (cfg_be[1]) m_base[15:8] = cfg_wdata[15:8];
            end
            if ((cfg_addr & 8'hFC) == 8'h3C && cfg_be[0]) m_line = cfg_wdata[3:0];
        end
        m_pend = chan_irq;
    endtask

    // one cycle: compare at falling edge, advance model after rising edge
    task automatic step(input string tag);
        @(negedge clk);
        chk(tag, "io_rdata",  {32'h0, io_rdata},  {32'h0, exp_io_rdata()});
        chk(tag, "cfg_rdata", {32'h0, cfg_rdata}, {32'h0, exp_cfg_rdata()});
        chk(tag, "dma_start", {62'h0, dma_start}, {62'h0, m_st[1][0], m_st[0][0]});
        chk(tag, "dma_table_addr", dma_table_addr, {m_tab[1], m_tab[0]});
        chk(tag, "irq_out",   {48'h0, irq_out},   {48'h0, exp_irq()});
        @(posedge clk);
        #1;
        model_update();
    endtask

    task automatic idle_in();
        io_req = 0; io_wr = 0; io_addr = 0; io_size = 0; io_wdata = 0;
        cfg_req = 0; cfg_wr = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
        evt_intr = 0; evt_err = 0;
    endtask

    task automatic io_w(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d, input string tag);
        io_req = 1; io_wr = 1; io_addr = a; io_size = s; io_wdata = d;
        step(tag);
        io_req = 0; io_wr = 0;
    endtask

    task automatic io_r(input logic [3:0] a, input logic [1:0] s, input string tag);
        io_req = 1; io_wr = 0; io_addr = a; io_size = s;
        step(tag);
        io_req = 0;
    endtask

    task automatic cfg_w(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
        cfg_req = 1; cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        step(tag);
        cfg_req = 0; cfg_wr = 0;
    endtask

    task automatic cfg_r(input logic [7:0] a, input string tag);
        cfg_req = 1; cfg_wr = 0; cfg_addr = a;
        step(tag);
        cfg_req = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1; chan_irq = 0;
        idle_in();
        @(posedge clk); #1; model_update();
        step("R1");
        rst = 0;
        // R1: reset values
        cfg_r(8'h3C, "R1"); cfg_r(8'h20, "R1"); cfg_r(8'h70, "R1");
        io_r(4'h2, 2'd0, "R1"); io_r(4'hC, 2'd2, "R1");
        // R5 / R2: command writes per channel
        io_w(4'h0, 2'd0, 32'h09, "R5"); io_r(4'h0, 2'd0, "R5"); io_r(4'h2, 2'd0, "R5");
        io_w(4'h8, 2'd0, 32'h01, "R2"); io_r(4'hA, 2'd0, "R2");
        io_w(4'h8, 2'd0, 32'h00, "R5");
        // R2: holes
        io_r(4'h1, 2'd0, "R2"); io_r(4'hB, 2'd0, "R2");
        io_w(4'h1, 2'd0, 32'h00, "R2"); io_w(4'h3, 2'd0, 32'hFF, "R2");
        io_r(4'h0, 2'd0, "R2"); io_r(4'h2, 2'd0, "R2");
        // R6: engine events
        evt_intr = 2'b01; evt_err = 2'b01; step("R6"); evt_intr = 0; evt_err = 0;
        io_r(4'h2, 2'd0, "R6");
        // R4: status write rules
        io_w(4'h2, 2'd0, 32'hFF, "R4"); io_r(4'h2, 2'd0, "R4");
        evt_intr = 2'b01; evt_err = 2'b01; step("R4"); evt_intr = 0; evt_err = 0;
        io_w(4'h2, 2'd0, 32'h02, "R4"); io_r(4'h2, 2'd0, "R4");
        io_w(4'h2, 2'd0, 32'h98, "R4"); io_r(4'h2, 2'd0, "R4");
        // R6: set beats same-cycle clear
        evt_intr = 2'b01; io_w(4'h2, 2'd0, 32'h06, "R6"); evt_intr = 0;
        io_r(4'h2, 2'd0, "R6");
        // R3: wide accesses on command/status
        io_w(4'h8, 2'd1, 32'h0000_0001, "R3"); io_w(4'h0, 2'd2, 32'h0, "R3");
        io_w(4'hA, 2'd3, 32'hFFFF_FFFF, "R3");
        io_r(4'h0, 2'd1, "R3"); io_r(4'h2, 2'd2, "R3"); io_r(4'hA, 2'd3, "R3");
        io_r(4'h8, 2'd0, "R3"); io_r(4'hA, 2'd0, "R3");
        // R7: pointer lanes
        io_w(4'h4, 2'd2, 32'h1234_5677, "R7"); io_r(4'h4, 2'd2, "R7");
        io_w(4'h5, 2'd0, 32'h0000_00AB, "R7"); io_w(4'h6, 2'd1, 32'h0000_CDEF, "R7");
        io_r(4'h4, 2'd2, "R7"); io_r(4'h4, 2'd0, "R7"); io_r(4'h6, 2'd1, "R7");
        io_r(4'h5, 2'd1, "R7"); io_r(4'h6, 2'd2, "R7");
        io_w(4'h5, 2'd1, 32'h0000_0000, "R7"); io_w(4'hE, 2'd2, 32'h1, "R7");
        io_w(4'hC, 2'd2, 32'hFFFF_FFFF, "R7"); io_r(4'hC, 2'd2, "R7");
        // R8: same-cycle reads while idle read zero
        step("R8");
        // R9 / R10: pending and routing
        chan_irq = 2'b01; step("R9"); cfg_r(8'h70, "R9"); cfg_r(8'h78, "R9");
        step("R10");
        cfg_w(8'h70, 4'hF, 32'h0, "R9"); cfg_r(8'h70, "R9");
        cfg_w(8'h3C, 4'h1, 32'h0, "R10"); step("R10");
        chan_irq = 2'b10; step("R10"); cfg_r(8'h78, "R9");
        cfg_w(8'h3C, 4'hF, 32'hFFFF_FFF3, "R11"); cfg_r(8'h3C, "R11"); step("R10");
        cfg_w(8'h3C, 4'hE, 32'h0000_0005, "R11"); cfg_r(8'h3C, "R11");
        chan_irq = 2'b11; step("R10"); chan_irq = 2'b00; step("R10"); step("R10");
        // R12: base register and unmapped space
        cfg_w(8'h20, 4'hF, 32'hFFFF_FFFF, "R12"); cfg_r(8'h20, "R12");
        cfg_w(8'h21, 4'h2, 32'h0000_1200, "R12"); cfg_r(8'h20, "R12");
        cfg_w(8'h10, 4'hF, 32'hFFFF_FFFF, "R12"); cfg_r(8'h10, "R12"); cfg_r(8'h74, "R12");
        // R1: reset in mid-run
        chan_irq = 2'b11; rst = 1; step("R1"); rst = 0; chan_irq = 0;
        step("R1"); cfg_r(8'h3C, "R1"); cfg_r(8'h20, "R1"); io_r(4'h4, 2'd2, "R1");
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            io_req   = 1'($urandom_range(0, 1));
            io_wr    = 1'($urandom_range(0, 1));
            io_addr  = 4'($urandom_range(0, 15));
            io_size  = 2'($urandom_range(0, 3));
            io_wdata = $urandom;
            cfg_req  = 1'($urandom_range(0, 1));
            cfg_wr   = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 4))
                0: cfg_addr = 8'h20;
                1: cfg_addr = 8'h3C;
                2: cfg_addr = 8'h70;
                3: cfg_addr = 8'h78;
                default: cfg_addr = 8'h14;
            endcase
            cfg_be    = 4'($urandom_range(0, 15));
            cfg_wdata = $urandom;
            chan_irq  = 2'($urandom_range(0, 3));
            evt_intr  = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            evt_err   = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            step("R8");
        end
        idle_in();
        step("R8");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule